// File: doc/BRIEF.md
# Line-Counted Polarity Inversion Generator

This block produces the alternating polarity signal that a liquid crystal output stage uses to keep a net DC bias off the cells. It counts line strobes and inverts the polarity after every N lines. N comes from a binary line-count select input.

A select value of zero puts the block in external mode. In that mode it releases the shared polarity pin by dropping its output enable, and passes the pin's input value to the output stage instead of its own register. Outside external mode the block drives the pin, and the output stage sees the generator register.

The block runs on a system clock. A line is one clock cycle with `line_stb` high. An asynchronous active-low reset returns the generator to a known starting point.

Top module: `fr_inversion_gen`

## Requirements
- R1: While `rst_n` is low, `fr_out` is 0 and the line count is zero. After release with select N, the first inversion comes on the N-th line strobe.
- R2: With select N in 2..31 (binary on `line_sel`), `fr_out` inverts on every N-th line strobe. It changes in the clock cycle that follows the edge that samples the strobe.
- R3: A select value of 1 behaves exactly like 2, so `fr_out` never inverts more often than every two lines.
- R4: The select value is captured on the first line strobe of each half period. A change made in the middle of a half period takes effect only from the next half period.
- R5: A select value of 0 sets `fr_oe` to 0, and `fr_int` then follows `fr_in`.
- R6: For any nonzero select value, `fr_oe` is 1 and `fr_int` equals `fr_out`.
- R7: `fr_out` does not change in a cycle whose preceding edge sampled `line_stb` low.
- R8: In external mode, line strobes leave `fr_out` unchanged and hold the line count at zero. On return to a nonzero select, a full half period of N strobes passes before the first inversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset of the generator |
| line_stb | input | 1 | One-cycle pulse per display line |
| line_sel | input | 5 | Lines per half period; 0 selects external polarity |
| fr_in | input | 1 | Polarity value read from the shared pin |
| fr_out | output | 1 | Generated polarity toward the pin driver |
| fr_oe | output | 1 | Pin driver enable; low in external mode |
| fr_int | output | 1 | Polarity used by the output stage |

## Verification
The assertions assume that `line_stb` is a synchronous one-cycle pulse and that `line_sel` only changes between clock edges. They also assume that `fr_in` is stable around the edges where its value is used. The bench drives every input on the falling clock edge, raises the strobe for exactly one cycle per line, and changes the select only while the strobe is low. This includes the mid-half-period change. Outputs are sampled on the falling edge that follows each strobe, after the register has updated.

// File: rtl/fr_inv_pkg.sv
package fr_inv_pkg;
   typedef enum logic {
      MODE_GEN = 1'b0,
      MODE_EXT = 1'b1
   } fr_mode_e;

   // Floor a requested line count so the half period never drops below the minimum.
   function automatic int unsigned clamp_lines(input int unsigned req, input int unsigned floor_v);
      return (req < floor_v) ? floor_v : req;
   endfunction
endpackage

// File: rtl/fr_mode_decode.sv
module fr_mode_decode
   import fr_inv_pkg::*;
#(
   parameter int SEL_W     = 5,
   parameter int MIN_LINES = 2
) (
   input  logic [SEL_W-1:0] line_sel,
   output fr_mode_e         mode,
   output logic [SEL_W-1:0] eff_lines
);
   localparam int unsigned MAX_SEL = (1 << SEL_W) - 1;

   generate
      if (MIN_LINES < 2 || MIN_LINES > MAX_SEL) begin : g_bad_min
         $error("fr_mode_decode: MIN_LINES out of range");
      end
   endgenerate

   always_comb begin
      mode      = (line_sel == '0) ? MODE_EXT : MODE_GEN;
      eff_lines = SEL_W'(clamp_lines(int'(line_sel), MIN_LINES));
   end

   always_comb begin
      assert_floor_R3: assert ((mode == MODE_EXT) || (eff_lines >= SEL_W'(MIN_LINES)))
         else $error("effective line count below floor");
   end
endmodule

// File: rtl/fr_half_counter.sv
module fr_half_counter #(
   parameter int SEL_W     = 5,
   parameter int MIN_LINES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_stb,
   input  logic             hold,
   input  logic [SEL_W-1:0] eff_lines,
   output logic             fr_q
);
   localparam int CNT_W = SEL_W;

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] lim_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt   <= '0;
         lim_q <= CNT_W'(MIN_LINES);
         fr_q  <= 1'b0;
      end else if (hold) begin
         cnt <= '0;
      end else if (line_stb) begin
         if (cnt == '0) begin
            lim_q <= eff_lines;
            cnt   <= CNT_W'(1);
         end else if (cnt == lim_q - 1'b1) begin
            cnt  <= '0;
            fr_q <= ~fr_q;
         end else begin
            cnt <= CNT_W'(cnt + 1'b1);
         end
      end
   end

   assert_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !line_stb |=> $stable(fr_q));
   assert_cnt_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt != '0) |-> (cnt < lim_q));
   assert_lim_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
      lim_q >= CNT_W'(MIN_LINES));
   assert_ext_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (cnt == '0) && $stable(fr_q));
   assert_reset_state_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (cnt == '0) && !fr_q);
endmodule

// File: rtl/fr_pin_mux.sv
module fr_pin_mux
   import fr_inv_pkg::*;
#(
   parameter bit EXT_SYNC = 1'b0
) (
   input  logic     clk,
   input  logic     rst_n,
   input  logic     line_stb,
   input  fr_mode_e mode,
   input  logic     fr_gen,
   input  logic     fr_in,
   output logic     fr_oe,
   output logic     fr_int
);
   logic ext_val;

   generate
      if (EXT_SYNC) begin : g_ext_sync
         logic ext_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        ext_q <= 1'b0;
            else if (line_stb) ext_q <= fr_in;
         end
         assign ext_val = ext_q;
      end else begin : g_ext_direct
         assign ext_val = fr_in;
      end
   endgenerate

   always_comb begin
      fr_oe  = (mode == MODE_GEN);
      fr_int = (mode == MODE_EXT) ? ext_val : fr_gen;
   end
endmodule

// File: rtl/fr_inversion_gen.sv
module fr_inversion_gen
   import fr_inv_pkg::*;
#(
   parameter int SEL_W     = 5,
   parameter int MIN_LINES = 2,
   parameter bit EXT_SYNC  = 1'b0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             line_stb,
   input  logic [SEL_W-1:0] line_sel,
   input  logic             fr_in,
   output logic             fr_out,
   output logic             fr_oe,
   output logic             fr_int
);
   fr_mode_e         mode;
   logic [SEL_W-1:0] eff_lines;
   logic             fr_gen;

   fr_mode_decode #(.SEL_W(SEL_W), .MIN_LINES(MIN_LINES)) u_decode (
      .line_sel (line_sel),
      .mode     (mode),
      .eff_lines(eff_lines)
   );

   fr_half_counter #(.SEL_W(SEL_W), .MIN_LINES(MIN_LINES)) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .line_stb (line_stb),
      .hold     (mode == MODE_EXT),
      .eff_lines(eff_lines),
      .fr_q     (fr_gen)
   );

   fr_pin_mux #(.EXT_SYNC(EXT_SYNC)) u_mux (
      .clk     (clk),
      .rst_n   (rst_n),
      .line_stb(line_stb),
      .mode    (mode),
      .fr_gen  (fr_gen),
      .fr_in   (fr_in),
      .fr_oe   (fr_oe),
      .fr_int  (fr_int)
   );

   assign fr_out = fr_gen;

   assert_drive_match_R6: assert property (@(posedge clk) disable iff (!rst_n)
      fr_oe |-> (fr_int == fr_out));
   assert_release_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (line_sel == '0) |-> !fr_oe);
endmodule

// File: tb/fr_inversion_gen_bench.sv
module fr_inversion_gen_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       line_stb = 1'b0;
   logic [4:0] line_sel = 5'd3;
   logic       fr_in = 1'b0;
   logic       fr_out, fr_oe, fr_int;
   int         n_chk = 0;
   int         n_bad = 0;

   always #2 clk = ~clk;

   fr_inversion_gen u_fr_inversion_gen (
      .clk(clk), .rst_n(rst_n), .line_stb(line_stb), .line_sel(line_sel),
      .fr_in(fr_in), .fr_out(fr_out), .fr_oe(fr_oe), .fr_int(fr_int)
   );

   localparam int NV = 14;
   localparam int V_SEL [NV] = '{3, 3, 3, 2, 1, 1, 5, 5, 5, 2, 2, 2, 31, 31};
   localparam int V_N   [NV] = '{2, 1, 3, 2, 1, 1, 4, 1, 2, 2, 1, 2, 30, 1};
   localparam int V_FR  [NV] = '{0, 1, 0, 1, 1, 0, 0, 1, 1, 1, 0, 1, 1, 0};

   task automatic check(input string req, input logic act, input logic exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %b expected %b", req, act, exp);
      end
   endtask

   task automatic lines(input int n);
      for (int i = 0; i < n; i++) begin
         @(negedge clk) line_stb = 1'b1;
         @(negedge clk) line_stb = 1'b0;
      end
   endtask

   task automatic finish_run();
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   endtask

   initial begin
      #400000;
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual running expected done");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 reset", fr_out, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      // Vector walk: R2 periods, R3 select 1, R4 mid-period change (vectors 9..12)
      for (int v = 0; v < NV; v++) begin
         line_sel = 5'(V_SEL[v]);
         lines(V_N[v]);
         check((v >= 8 && v <= 11) ? "R4 change" : (V_SEL[v] == 1 ? "R3 sel1" : "R2 period"),
               fr_out, 1'(V_FR[v]));
         check("R6 oe", fr_oe, 1'b1);
         check("R6 int", fr_int, fr_out);
      end

      // R7: clock cycles without a strobe leave fr_out alone
      repeat (6) @(negedge clk);
      check("R7 idle", fr_out, 1'b0);

      // R5 / R8: external mode
      line_sel = 5'd0;
      fr_in = 1'b1;
      @(negedge clk);
      check("R5 oe", fr_oe, 1'b0);
      check("R5 int hi", fr_int, 1'b1);
      lines(3);
      check("R8 ext hold", fr_out, 1'b0);
      fr_in = 1'b0;
      @(negedge clk);
      check("R5 int lo", fr_int, 1'b0);
      line_sel = 5'd2;
      lines(1);
      check("R8 restart", fr_out, 1'b0);
      lines(1);
      check("R8 restart", fr_out, 1'b1);

      // R1: reset mid-count, then a full half period
      line_sel = 5'd3;
      lines(1);
      @(negedge clk) rst_n = 1'b0;
      @(negedge clk);
      check("R1 in reset", fr_out, 1'b0);
      rst_n = 1'b1;
      lines(2);
      check("R1 after release", fr_out, 1'b0);
      lines(1);
      check("R1 after release", fr_out, 1'b1);
      check("R6 oe end", fr_oe, 1'b1);

      finish_run();
   end
endmodule